// File: doc/BRIEF.md
# Strobe-Handshake Fall-Through FIFO

This block is a 64-word first-in/first-out buffer whose two sides are driven by slow level strobes instead of by valid/ready pulses. A writer raises its shift-in strobe while the input-ready flag is high. The block captures the input word and drops input-ready. When the writer lowers the strobe, the word is committed to the queue. The reader works the same way with its shift-out strobe and the output-ready flag. Raising the strobe acknowledges the word on the output pins. Lowering it consumes that word and lets the next stored word fall through to the outputs.

Both strobes are sampled on one system clock through a short synchronizer chain, so either side may toggle at any rate slower than the clock. Storage is a two-port RAM addressed by separate write and read pointers, and a 7-bit occupancy count tracks full and empty. Several stages can be chained for more depth: output-ready of one stage drives shift-in of the next, and input-ready of the next drives shift-out of the one before.

An active-low master reset empties the queue and clears the outputs. An active-low output enable lets the data pins share a bus.

Top module: `strobe_fifo`

## Requirements
- R1: The queue holds exactly DEPTH (64) words of DATA_W bits (4 or 5). After DEPTH committed writes with no reads, `in_ready` is low.
- R2: With `in_ready` high, raising `shift_in` captures `din` and drives `in_ready` low. Lowering `shift_in` commits the word, and `in_ready` returns high unless the queue is now full.
- R3: A `shift_in` pulse while `in_ready` is low writes nothing. While the queue is full, `in_ready` stays low until a word has been consumed.
- R4: With `out_ready` high, raising `shift_out` drives `out_ready` low and keeps `dout` unchanged. Lowering `shift_out` consumes the word, and the next stored word, if any, appears on `dout` with `out_ready` high.
- R5: A `shift_out` pulse while `out_ready` is low has no effect. When the queue is empty, `dout` keeps the last word read and `out_ready` is low.
- R6: While `rst_n` is low, `in_ready` is high, `out_ready` is low and `dout` is all zeros. Any stored words are discarded.
- R7: If `shift_in` is high when `rst_n` is released, `din` is written and `in_ready` goes low until `shift_in` falls.
- R8: When a full queue is read while `shift_in` is held high, the freed slot is filled from `din` without a new strobe, and `in_ready` is low again once `shift_in` falls.
- R9: If `shift_out` is held high while the queue is empty and a word arrives, `out_ready` is high for exactly one clock, and the word stays on `dout`. Later words queue behind it until `shift_out` falls. The next word then appears with `out_ready` high.
- R10: While `oe_n` is high, every `dout` bit is high impedance. When `oe_n` goes low, the held word returns.
- R11: Words leave in the order they were committed under any interleaving of writes and reads, including overlapping ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both strobes |
| rst_n | input | 1 | Master reset, active low, asynchronous assert |
| shift_in | input | 1 | Write strobe; the rise captures and the fall commits |
| din | input | DATA_W | Word to be written |
| in_ready | output | 1 | High when a write strobe will be accepted |
| shift_out | input | 1 | Read strobe; the rise acknowledges and the fall consumes |
| out_ready | output | 1 | High when `dout` holds an unconsumed word |
| oe_n | input | 1 | Output enable, active low; high makes `dout` high impedance |
| dout | output | DATA_W | Head word of the queue, or the last word read when empty |

## Verification
The in-RTL assertions check four things on every cycle: occupancy never exceeds the depth, `in_ready` is low whenever the queue is full, `out_ready` is never high over an empty queue, and `dout` changes only when the head register is reloaded. They also check that accepting a read strobe drops `out_ready` on the next clock.

Some behaviours involve a history of strobes and only the bench scenarios can show them:
- ignored pulses on either side;
- the single-clock `out_ready` pulse with `shift_out` held high;
- the automatic refill of a full queue while `shift_in` stays high;
- the write taken at reset release;
- end-to-end word ordering against a reference queue.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  // Pointer advance with wrap at an arbitrary limit.
  function automatic int unsigned wrap_inc(input int unsigned value, input int unsigned limit);
    return (value + 1 >= limit) ? 0 : value + 1;
  endfunction

  // Occupancy after one cycle of commits on both sides.
  function automatic int unsigned occ_after(input int unsigned occ, input logic wr_done,
                                            input logic rd_done);
    return occ + (wr_done ? 1 : 0) - (rd_done ? 1 : 0);
  endfunction

endpackage

// File: rtl/sfifo_strobe_sync.sv
module sfifo_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic level
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= strobe;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], strobe};
      end
    end
  endgenerate

  assign level = chain[STAGES-1];
endmodule

// File: rtl/sfifo_ram.sv
module sfifo_ram #(
  parameter int W     = 4,
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import sfifo_pkg::*;
#(
  parameter int DATA_W      = 4,
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_in,
  input  logic [DATA_W-1:0] din,
  output logic              in_ready,
  input  logic              shift_out,
  output logic              out_ready,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW = $clog2(DEPTH + 1);
  localparam logic [OW-1:0] FULL_OCC = OW'(DEPTH);

  // Synchronised strobe levels
  logic si_lvl, so_lvl;

  sfifo_strobe_sync #(.STAGES(SYNC_STAGES)) i_si_sync (
    .clk(clk), .rst_n(rst_n), .strobe(shift_in), .level(si_lvl));
  sfifo_strobe_sync #(.STAGES(SYNC_STAGES)) i_so_sync (
    .clk(clk), .rst_n(rst_n), .strobe(shift_out), .level(so_lvl));

  // State
  logic [AW-1:0]     wptr, rptr;
  logic [OW-1:0]     occ, occ_nx;
  logic              wr_pend, rd_pend, head_valid;
  logic [DATA_W-1:0] dout_q, ram_rdata;

  // Named internal events
  logic wr_take, wr_commit, rd_take, rd_commit, head_load;

  assign wr_take   = si_lvl & in_ready;
  assign wr_commit = wr_pend & ~si_lvl;
  assign rd_take   = so_lvl & out_ready;
  assign rd_commit = rd_pend & ~so_lvl;
  assign head_load = ~head_valid & (occ != '0);
  assign occ_nx    = OW'(occ_after(int'(occ), wr_commit, rd_commit));

  sfifo_ram #(.W(DATA_W), .DEPTH(DEPTH), .AW(AW)) i_ram (
    .clk(clk), .we(wr_take), .waddr(wptr), .wdata(din),
    .raddr(rptr), .rdata(ram_rdata));

  // Write side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      wr_pend  <= 1'b0;
      in_ready <= 1'b1;
    end else begin
      if (wr_take) begin
        wr_pend  <= 1'b1;
        in_ready <= 1'b0;
      end else if (wr_commit) begin
        wr_pend  <= 1'b0;
        wptr     <= AW'(wrap_inc(int'(wptr), DEPTH));
        in_ready <= (occ_nx < FULL_OCC);
      end else if (!wr_pend) begin
        in_ready <= (occ_nx < FULL_OCC);
      end
    end
  end

  // Occupancy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ_nx;
  end

  // Read side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr       <= '0;
      rd_pend    <= 1'b0;
      head_valid <= 1'b0;
      dout_q     <= '0;
    end else begin
      if (rd_commit) begin
        rd_pend    <= 1'b0;
        head_valid <= 1'b0;
        rptr       <= AW'(wrap_inc(int'(rptr), DEPTH));
      end else if (rd_take) begin
        rd_pend <= 1'b1;
      end else if (head_load) begin
        head_valid <= 1'b1;
        dout_q     <= ram_rdata;
      end
    end
  end

  assign out_ready = head_valid & ~rd_pend;
  assign dout      = oe_n ? {DATA_W{1'bz}} : dout_q;

  // Assertions
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL_OCC);                                                   // R1
  AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == FULL_OCC) |-> !in_ready);                                   // R3
  AST_OR_DROP_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> !out_ready);                                            // R4
  AST_OR_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> (occ != '0));                                         // R5
  AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !head_load |=> $stable(dout_q));                                    // R5
endmodule

// File: tb/test_strobe_fifo.sv
module test_strobe_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 4;
  localparam int DEPTH      = 64;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n, si, so, oe_n;
  logic [DW-1:0] din;
  logic in_ready, out_ready;
  logic [DW-1:0] dout;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int or_hi_cnt = 0;
  bit done = 1'b0;
  logic [DW-1:0] q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) i_strobe_fifo (
    .clk(clk), .rst_n(rst_n), .shift_in(si), .din(din), .in_ready(in_ready),
    .shift_out(so), .out_ready(out_ready), .oe_n(oe_n), .dout(dout));

  always @(negedge clk) begin
    cycles++;
    if (out_ready) or_hi_cnt++;
  end

  initial begin
    wait (cycles >= WATCHDOG);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run hung, actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic bit exp_in_ready(input int n);
    return n < DEPTH;
  endfunction

  function automatic bit exp_out_ready(input int n);
    return n > 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_flags(input string req);
    chk(in_ready === exp_in_ready(q.size()), req, int'(in_ready), int'(exp_in_ready(q.size())));
    chk(out_ready === exp_out_ready(q.size()), req, int'(out_ready), int'(exp_out_ready(q.size())));
  endtask

  // One write strobe; returns whether input-ready dropped during it.
  task automatic push(input logic [DW-1:0] d, output bit dropped);
    int t;
    din = d;
    si  = 1'b1;
    t   = 0;
    while (in_ready && t < 20) begin
      @(negedge clk);
      t++;
    end
    dropped = !in_ready;
    si = 1'b0;
    wait_cyc(6);
    q.push_back(d);
  endtask

  task automatic pop(input string req);
    int t;
    chk(dout === q[0], req, int'(dout), int'(q[0]));
    so = 1'b1;
    t  = 0;
    while (out_ready && t < 20) begin
      @(negedge clk);
      t++;
    end
    so = 1'b0;
    wait_cyc(6);
    void'(q.pop_front());
  endtask

  initial begin
    bit dr;
    logic [DW-1:0] last, wa, wb;
    rst_n = 1'b0; si = 1'b0; so = 1'b0; oe_n = 1'b0; din = '0;
    void'($urandom(1234));
    wait_cyc(5);

    // R6: reset state
    chk(in_ready === 1'b1, "R6", int'(in_ready), 1);
    chk(out_ready === 1'b0, "R6", int'(out_ready), 0);
    chk(dout === '0, "R6", int'(dout), 0);
    rst_n = 1'b1;
    wait_cyc(4);

    // R2 / R4: basic write and read handshakes
    push(4'h3, dr);
    chk(dr, "R2", int'(dr), 1);
    check_flags("R2");
    chk(dout === 4'h3, "R4", int'(dout), 3);
    push(4'hA, dr);
    push(4'h5, dr);
    check_flags("R2");
    pop("R4");
    check_flags("R4");
    pop("R4");
    pop("R4");
    check_flags("R5");

    // R5: last word held, SO pulse while empty ignored
    chk(dout === 4'h5, "R5", int'(dout), 5);
    so = 1'b1; wait_cyc(8); so = 1'b0; wait_cyc(6);
    chk(dout === 4'h5, "R5", int'(dout), 5);
    chk(out_ready === 1'b0, "R5", int'(out_ready), 0);
    push(4'hC, dr);
    chk(dout === 4'hC, "R5", int'(dout), 12);
    chk(out_ready === 1'b1, "R5", int'(out_ready), 1);

    // R10: output enable
    oe_n = 1'b1; wait_cyc(1);
    chk(dout === {DW{1'bz}}, "R10", int'(dout), 0);
    oe_n = 1'b0; wait_cyc(1);
    chk(dout === 4'hC, "R10", int'(dout), 12);
    pop("R10");

    // R1: fill to capacity
    for (int i = 0; i < DEPTH; i++) push(DW'(i * 7 + 1), dr);
    chk(in_ready === 1'b0, "R1", int'(in_ready), 0);
    chk(out_ready === 1'b1, "R1", int'(out_ready), 1);
    // R3: write strobe while full is ignored
    din = 4'hF; si = 1'b1; wait_cyc(8); si = 1'b0; wait_cyc(6);
    chk(in_ready === 1'b0, "R3", int'(in_ready), 0);
    // R8: read a full queue with SI held high
    din = 4'h9; si = 1'b1; wait_cyc(4);
    pop("R8");
    wait_cyc(4);
    si = 1'b0; wait_cyc(6);
    q.push_back(4'h9);
    chk(in_ready === 1'b0, "R8", int'(in_ready), 0);
    chk(q.size() == DEPTH, "R8", q.size(), DEPTH);
    while (q.size() > 0) pop("R3");
    check_flags("R3");

    // R9: SO held high while empty
    last = 4'h9;
    chk(dout === last, "R5", int'(dout), int'(last));
    so = 1'b1; wait_cyc(6);
    or_hi_cnt = 0;
    wa = 4'h6; wb = 4'hB;
    push(wa, dr);
    wait_cyc(4);
    chk(or_hi_cnt == 1, "R9", or_hi_cnt, 1);
    chk(dout === wa, "R9", int'(dout), int'(wa));
    push(wb, dr);
    chk(out_ready === 1'b0, "R9", int'(out_ready), 0);
    chk(dout === wa, "R9", int'(dout), int'(wa));
    so = 1'b0; wait_cyc(8);
    void'(q.pop_front());
    chk(out_ready === 1'b1, "R9", int'(out_ready), 1);
    chk(dout === wb, "R9", int'(dout), int'(wb));
    pop("R9");

    // R7: SI high at reset release
    rst_n = 1'b0; din = 4'hD; si = 1'b1;
    wait_cyc(4);
    q.delete();
    rst_n = 1'b1;
    wait_cyc(6);
    chk(in_ready === 1'b0, "R7", int'(in_ready), 0);
    si = 1'b0; wait_cyc(8);
    q.push_back(4'hD);
    chk(out_ready === 1'b1, "R7", int'(out_ready), 1);
    chk(in_ready === 1'b1, "R7", int'(in_ready), 1);
    pop("R7");

    // R11: random interleaving against the reference queue
    for (int n = 0; n < 300; n++) begin
      int op;
      op = int'($urandom_range(0, 2));
      if (op != 0 && q.size() < DEPTH) push(DW'($urandom()), dr);
      else if (q.size() > 0) pop("R11");
      if (n % 10 == 0) check_flags("R11");
    end
    while (q.size() > 0) pop("R11");
    check_flags("R11");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule